// File: doc/BRIEF.md
# Four-Way Write-Through Cache with Tree Pseudo-LRU Replacement

This block is an 8 KB cache that sits between a 32-bit processor port and a slower memory port. Instructions and data share it. It is organised as 128 sets of four ways, and each way holds a 16-byte line of four 32-bit words. A read that hits is answered from the cache. A read that misses fetches the whole line from memory in a four-beat burst and then answers. Every write goes to memory as a single-word write. A write also updates the cached word if the line is present, and it never allocates a line.

The processor holds `cpu_req` with its address, direction and write data until `cpu_ready` pulses for one cycle. Only one request is in flight at a time. On the memory side a level request starts a line burst, with one beat returned per `mem_rd_valid` cycle. Word writes are held until `mem_wr_ack`. Each set keeps four valid bits and three tree bits for choosing a victim. A one-cycle `flush` input invalidates the whole cache.

Top module: `wt_cache4`

## Requirements
- R1: After a synchronous active-low reset, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low and every line is invalid, so the first read of any address misses.
- R2: The address is split into byte offset [3:0], word select [3:2], set index [10:4] and tag [31:11]. A read that hits in a valid way raises `cpu_ready` with the stored word and makes no memory request.
- R3: A read miss raises `mem_rd_req` with the line address (bits [3:0] zero) and accepts exactly four beats. Beat k carries the word at line address + 4k. The requested word is returned only after the fourth beat.
- R4: Every write issues exactly one memory write with the processor's full address and data, held stable until `mem_wr_ack`. `cpu_ready` follows the acknowledge.
- R5: A write that hits also replaces the cached word, so a later read returns the new data without a fill.
- R6: A write that misses does not allocate: a later read of that line misses and fills.
- R7: On a read miss with an invalid way in the set, the lowest-numbered invalid way is filled.
- R8: With all four ways valid, the victim comes from tree bits T0,T1,T2. T0=0 picks way 0 when T1=0 and way 1 when T1=1. T0=1 picks way 2 when T2=0 and way 3 when T2=1.
- R9: Each read hit, write hit and completed fill updates the set's tree away from the used way. Way 0 sets T0=1,T1=1. Way 1 sets T0=1,T1=0. Way 2 sets T0=0,T2=1. Way 3 sets T0=0,T2=0. A write miss leaves the tree unchanged.
- R10: A one-cycle `flush` pulse invalidates every line by the next cycle. If a fill completes in the same cycle, the flush wins.
- R11: `cpu_ready` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| mem_rd_req | output | 1 | Line burst request (level) |
| mem_rd_addr | output | 32 | Line-aligned burst address |
| mem_rd_valid | input | 1 | Burst beat valid |
| mem_rd_data | input | 32 | Burst beat data |
| mem_wr_req | output | 1 | Word write request (level) |
| mem_wr_addr | output | 32 | Word write address |
| mem_wr_data | output | 32 | Word write data |
| mem_wr_ack | input | 1 | Word write accepted |

## Verification
The bench keeps its own model of valid bits, tags and tree bits for four sets. Six competing tags cause evictions, so a wrong victim order or a missed tree update shows up as a fill where a hit was predicted, or the reverse. Write hits are followed by reads of the same words, so a design that skips the cache update returns stale data. Write misses are followed by reads, so a design that allocates on a write miss hits where a fill was due. Reads right after a flush or a second reset catch lines that stay valid. The burst is checked for exactly four beats and a line-aligned address, with the requested word taken from its own beat rather than from the first or last one.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through cache.
// Assumes a fixed four-way organisation because the replacement tree has
// exactly three decision bits.
package wtc_pkg;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_WRITE,
        ST_RESP
    } wtc_state_t;
endpackage

// File: rtl/wtc_plru.sv
// Per-set three-bit tree replacement state and victim choice.
// The victim is the lowest invalid way if one exists; otherwise the tree is walked.
// Assumes at most one update per cycle and synchronous active-low reset.
module wtc_plru import wtc_pkg::*; #(
    parameter int SETS = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  look_set,
    input  logic [WAYS-1:0]          look_valid,
    output logic [WAY_W-1:0]         victim,
    input  logic                     upd_en,
    input  logic [$clog2(SETS)-1:0]  upd_set,
    input  logic [WAY_W-1:0]         upd_way
);
    localparam int IDX_W = $clog2(SETS);

    logic [TREE_W-1:0] tree_q [SETS];
    logic [TREE_W-1:0] cur;

    // Victim selection: invalid ways first, then the tree walk.
    always_comb begin
        cur = tree_q[look_set];
        if (!look_valid[0])      victim = 2'd0;
        else if (!look_valid[1]) victim = 2'd1;
        else if (!look_valid[2]) victim = 2'd2;
        else if (!look_valid[3]) victim = 2'd3;
        else if (!cur[0])        victim = cur[1] ? 2'd1 : 2'd0;
        else                     victim = cur[2] ? 2'd3 : 2'd2;
    end

    // Tree update: steer the bits away from the way just used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (upd_en) begin
            case (upd_way)
                2'd0: begin tree_q[upd_set][0] <= 1'b1; tree_q[upd_set][1] <= 1'b1; end
                2'd1: begin tree_q[upd_set][0] <= 1'b1; tree_q[upd_set][1] <= 1'b0; end
                2'd2: begin tree_q[upd_set][0] <= 1'b0; tree_q[upd_set][2] <= 1'b1; end
                default: begin tree_q[upd_set][0] <= 1'b0; tree_q[upd_set][2] <= 1'b0; end
            endcase
        end
    end

    // R9
    mru_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_en) && look_set == $past(upd_set) && (&look_valid))
        |-> victim != $past(upd_way));

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/wtc_tag_match.sv
// Parallel tag comparison: one comparator per way for the selected set.
// Assumes at most one valid way holds a given tag.
module wtc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 21
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           probe_tag,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way
);
    localparam int WSEL_W = $clog2(WAYS);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tags[g] == probe_tag);
    end

    // Encode the matching way; the lowest index wins.
    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) hit_way = WSEL_W'(i);
        end
    end
endmodule

// File: rtl/wtc_data_store.sv
// Line data storage with one synchronous write port and one combinational read port.
// Assumes SETS, WAYS and BEATS are powers of two so the index is a concatenation.
module wtc_data_store #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int BEATS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [$clog2(BEATS)-1:0]  wr_word,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic [$clog2(WAYS)-1:0]   rd_way,
    input  logic [$clog2(BEATS)-1:0]  rd_word,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int DEPTH = SETS * WAYS * BEATS;

    logic [DATA_W-1:0] words_q [DEPTH];

    // Word write from a fill beat or a write hit.
    always_ff @(posedge clk) begin
        if (we) words_q[{wr_set, wr_way, wr_word}] <= wr_data;
    end

    // Word read for a hit.
    assign rd_data = words_q[{rd_set, rd_way, rd_word}];
endmodule

// File: rtl/wt_cache4.sv
// Four-way write-through cache top: request capture, lookup, burst fill,
// write-through and response sequencing.
// Assumes one outstanding processor request, a memory that returns exactly
// four beats per burst request, and a synchronous active-low reset.
module wt_cache4 import wtc_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFFS_W = $clog2(LINE_BYTES);
    localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

    wtc_state_t         state_q;
    logic [ADDR_W-1:0]  req_addr_q;
    logic               req_we_q;
    logic [DATA_W-1:0]  req_wdata_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [WAY_W-1:0]   victim_q;
    logic [BEAT_W-1:0]  beat_q;
    logic [WAYS-1:0]    valid_q [SETS];
    logic [TAG_W-1:0]   tag_q   [SETS][WAYS];

    logic [IDX_W-1:0]   req_set;
    logic [TAG_W-1:0]   req_tag;
    logic [BEAT_W-1:0]  req_word;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAYS-1:0]    set_valid;
    logic               hit;
    logic [WAY_W-1:0]   hit_way;
    logic [WAY_W-1:0]   victim;
    logic               fill_last;
    logic               ds_we;
    logic [WAY_W-1:0]   ds_way;
    logic [BEAT_W-1:0]  ds_word;
    logic [DATA_W-1:0]  ds_wdata;
    logic [DATA_W-1:0]  ds_rdata;
    logic               tree_upd;
    logic [WAY_W-1:0]   tree_way;
    logic               any_valid;

    // Address fields of the captured request.
    assign req_set  = req_addr_q[OFFS_W +: IDX_W];
    assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
    assign req_word = req_addr_q[BYTE_W +: BEAT_W];

    // Gather the tags and valid bits of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_set][w];
        set_valid = valid_q[req_set];
    end

    wtc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .probe_tag (req_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    assign fill_last = (state_q == ST_FILL) && mem_rd_valid && (beat_q == BEAT_W'(BEATS - 1));

    // Single write port: fill beats or write-hit data.
    always_comb begin
        ds_we    = ((state_q == ST_LOOKUP) && req_we_q && hit)
                 || ((state_q == ST_FILL) && mem_rd_valid);
        ds_way   = (state_q == ST_FILL) ? victim_q    : hit_way;
        ds_word  = (state_q == ST_FILL) ? beat_q      : req_word;
        ds_wdata = (state_q == ST_FILL) ? mem_rd_data : req_wdata_q;
    end

    wtc_data_store #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .we      (ds_we),
        .wr_set  (req_set),
        .wr_way  (ds_way),
        .wr_word (ds_word),
        .wr_data (ds_wdata),
        .rd_set  (req_set),
        .rd_way  (hit_way),
        .rd_word (req_word),
        .rd_data (ds_rdata)
    );

    // Replacement update on any hit in lookup or on the final fill beat.
    always_comb begin
        tree_upd = ((state_q == ST_LOOKUP) && hit) || fill_last;
        tree_way = (state_q == ST_FILL) ? victim_q : hit_way;
    end

    wtc_plru #(.SETS(SETS)) u_plru (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_set   (req_set),
        .look_valid (set_valid),
        .victim     (victim),
        .upd_en     (tree_upd),
        .upd_set    (req_set),
        .upd_way    (tree_way)
    );

    // Valid bits: drop the victim at miss, set after the last beat, flush wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else begin
            if ((state_q == ST_LOOKUP) && !req_we_q && !hit) valid_q[req_set][victim] <= 1'b0;
            if (fill_last) valid_q[req_set][victim_q] <= 1'b1;
            if (flush) begin
                for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end
        end
    end

    // Tag write when a fill completes.
    always_ff @(posedge clk) begin
        if (fill_last) tag_q[req_set][victim_q] <= req_tag;
    end

    // Request sequencing and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
            victim_q    <= '0;
            beat_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_addr_q  <= cpu_addr;
                        req_we_q    <= cpu_we;
                        req_wdata_q <= cpu_wdata;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (req_we_q) begin
                        state_q <= ST_WRITE;
                    end else if (hit) begin
                        rdata_q <= ds_rdata;
                        state_q <= ST_RESP;
                    end else begin
                        victim_q <= victim;
                        beat_q   <= '0;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        if (beat_q == req_word) rdata_q <= mem_rd_data;
                        beat_q <= beat_q + 1'b1;
                        if (fill_last) state_q <= ST_RESP;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ack) state_q <= ST_RESP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer.
    assign cpu_ready   = (state_q == ST_RESP);
    assign cpu_rdata   = rdata_q;
    assign mem_rd_req  = (state_q == ST_FILL);
    assign mem_rd_addr = {req_addr_q[ADDR_W-1:OFFS_W], OFFS_W'(0)};
    assign mem_wr_req  = (state_q == ST_WRITE);
    assign mem_wr_addr = req_addr_q;
    assign mem_wr_data = req_wdata_q;

    // Any line valid anywhere, for the flush check.
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
    end

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R2
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !req_we_q && hit) |=> (cpu_ready && !mem_rd_req));

    // R3
    fill_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid && beat_q != BEAT_W'(BEATS - 1)) |=> (mem_rd_req && !cpu_ready));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R4
    wr_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && req_we_q) |=> mem_wr_req);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !any_valid);
endmodule

// File: tb/tb_wt_cache4.sv
module tb_wt_cache4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;

    always #4 clk = ~clk;

    wt_cache4 dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Memory model over tags 0..7, sets 0..3, words 0..3.
    logic [31:0] bmem [128];
    bit          written [128];
    int          fill_cnt = 0, beat_cnt = 0, wr_cnt = 0;
    logic [31:0] last_fill_addr = '0, last_wr_addr = '0, last_wr_data = '0;

    // Cache model.
    bit          mv [4][4];
    int          mt [4][4];
    bit [2:0]    mp [4];

    function automatic int idx(input logic [31:0] a);
        return int'({a[13:11], a[5:4], a[3:2]});
    endfunction

    function automatic int mvict(input int s);
        for (int w = 0; w < 4; w++) if (!mv[s][w]) return w;
        if (!mp[s][0]) return mp[s][1] ? 1 : 0;
        return mp[s][2] ? 3 : 2;
    endfunction

    function automatic void mupd(input int s, input int w);
        case (w)
            0: begin mp[s][0] = 1; mp[s][1] = 1; end
            1: begin mp[s][0] = 1; mp[s][1] = 0; end
            2: begin mp[s][0] = 0; mp[s][2] = 1; end
            default: begin mp[s][0] = 0; mp[s][2] = 0; end
        endcase
    endfunction

    function automatic void mclear();
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 4; w++) mv[s][w] = 0;
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: burst fills and acknowledged word writes.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                fill_cnt++;
                last_fill_addr = mem_rd_addr;
                @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = bmem[idx(last_fill_addr + 32'(b * 4))];
                    beat_cnt++;
                    @(negedge clk);
                end
                mem_rd_valid = 1'b0;
            end else if (mem_wr_req) begin
                @(negedge clk);
                mem_wr_ack   = 1'b1;
                wr_cnt++;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
                bmem[idx(mem_wr_addr)]    = mem_wr_data;
                written[idx(mem_wr_addr)] = 1;
                @(negedge clk);
                mem_wr_ack = 1'b0;
            end
        end
    end

    task automatic access(input bit we, input int tg, input int st, input int wd, input logic [31:0] wdat);
        logic [31:0] a;
        logic [31:0] got;
        int hw, f0, b0, w0, v;
        bit full;
        a  = 32'(tg << 11) | 32'(st << 4) | 32'(wd << 2);
        hw = -1;
        for (int w = 0; w < 4; w++) if (mv[st][w] && mt[st][w] == tg) hw = w;
        full = mv[st][0] && mv[st][1] && mv[st][2] && mv[st][3];
        f0 = fill_cnt; b0 = beat_cnt; w0 = wr_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wdat;
        do @(negedge clk); while (!cpu_ready);
        got = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        check(!cpu_ready, "R11 ready pulse", 32'(cpu_ready), 32'd0);
        if (we) begin
            check(wr_cnt - w0 == 1, "R4 write count", 32'(wr_cnt - w0), 32'd1);
            check(last_wr_addr == a && last_wr_data == wdat, "R4 write addr/data", last_wr_data, wdat);
            check(fill_cnt == f0, "R6 no fill on write", 32'(fill_cnt - f0), 32'd0);
            if (hw >= 0) mupd(st, hw);
        end else begin
            if (hw >= 0) begin
                check(fill_cnt == f0, "R2 hit without fill", 32'(fill_cnt - f0), 32'd0);
                mupd(st, hw);
            end else begin
                if (full) check(fill_cnt - f0 == 1, "R8 R9 victim miss", 32'(fill_cnt - f0), 32'd1);
                else      check(fill_cnt - f0 == 1, "R7 R6 miss fill", 32'(fill_cnt - f0), 32'd1);
                check(beat_cnt - b0 == 4, "R3 four beats", 32'(beat_cnt - b0), 32'd4);
                check(last_fill_addr == (a & ~32'hF), "R3 line address", last_fill_addr, a & ~32'hF);
                v = mvict(st);
                mv[st][v] = 1; mt[st][v] = tg;
                mupd(st, v);
            end
            if (written[idx(a)]) check(got == bmem[idx(a)], "R5 updated word", got, bmem[idx(a)]);
            else                 check(got == bmem[idx(a)], "R3 read data", got, bmem[idx(a)]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mclear();
        for (int s = 0; s < 4; s++) mp[s] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++; compared++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        int f0;
        lf = 32'h1ACE_5EED;
        for (int i = 0; i < 128; i++) begin
            bmem[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0107);
            written[i] = 0;
        end
        do_reset();
        @(negedge clk);
        check(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1 reset outputs",
              {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
        f0 = fill_cnt;
        access(0, 0, 0, 0, '0);
        check(fill_cnt - f0 == 1, "R1 first read misses", 32'(fill_cnt - f0), 32'd1);

        // Fill set 0 with four tags, then hit each, then force evictions.
        for (int t = 1; t < 4; t++) access(0, t, 0, t, '0);
        for (int t = 0; t < 4; t++) access(0, t, 0, 3 - t, '0);
        for (int t = 4; t < 8; t++) access(0, t, 0, 1, '0);
        for (int t = 0; t < 8; t++) access(0, t, 0, 2, '0);

        // Write miss then read: no allocation.
        access(1, 7, 1, 2, 32'hDEAD_0001);
        access(0, 7, 1, 2, '0);
        // Write hit then read: cached word updated.
        access(1, 7, 1, 2, 32'hBEEF_0002);
        access(0, 7, 1, 2, '0);

        // Sweep with six competing tags.
        for (int i = 0; i < 1500; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            access(lf[1:0] == 2'b00, int'(lf[10:8]) % 6, int'(lf[5:4]), int'(lf[7:6]), lf ^ 32'h5A5A_A5A5);
        end

        // Flush: every subsequent read misses.
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        mclear();
        for (int s = 0; s < 4; s++) begin
            f0 = fill_cnt;
            access(0, 0, s, 0, '0);
            check(fill_cnt - f0 == 1, "R10 miss after flush", 32'(fill_cnt - f0), 32'd1);
        end
        for (int i = 0; i < 200; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            access(lf[2:0] == 3'b000, int'(lf[10:8]) % 6, int'(lf[5:4]), int'(lf[7:6]), lf);
        end

        // Second reset invalidates everything.
        do_reset();
        f0 = fill_cnt;
        access(0, 1, 2, 3, '0);
        check(fill_cnt - f0 == 1, "R1 miss after reset", 32'(fill_cnt - f0), 32'd1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule